// File: doc/BRIEF.md
# Epoch-Synchronized Integrate-and-Dump Accumulator

This block integrates the correlation products of one correlator arm in a spread-spectrum tracking channel. On every sample clock with the enable high it adds a small signed product to a running 16-bit sum. The channel's code generator raises a one-cycle dump pulse at the end of each code epoch, nominally once per millisecond. On that pulse the block publishes the finished epoch sum on a held output register with a one-cycle valid strobe, and then starts the next epoch from zero. Each channel has its own dump timing, so separate instances are not aligned with each other.

A small controller has two states. `ST_WAIT` is entered at reset. In this state samples are discarded, because the first epoch boundary has not been seen yet. The transition *first epoch* (`ST_WAIT` to `ST_INTEG`, taken on the first dump pulse) aligns integration with the received code. `ST_INTEG` then holds through the transition *epoch dump* (`ST_INTEG` to `ST_INTEG`, taken on every later dump pulse). Only reset returns the controller to `ST_WAIT`.

While tracking, twenty epochs make up one data bit. A dump counter therefore raises a bit-boundary strobe on every twentieth reported dump. An external resync input realigns this counter. When an addition would leave the 16-bit range, the sum clips to the nearest limit. The overflow is then reported together with that epoch's result.

Top module: `epoch_integrator`

## Requirements
- R1: During and right after reset, `dump_sum` is 0, `dump_vld`, `dump_ovf` and `bit_edge` are 0, the controller is in `ST_WAIT`, and the dump counter is 0.
- R2: In `ST_WAIT`, samples are ignored. The first dump pulse produces no `dump_vld`. It moves the controller to `ST_INTEG` with the running sum at zero, so the sample on that dump cycle is also discarded. This dump is not counted.
- R3: In `ST_INTEG`, `smp_prod` is read as 4-bit two's complement (-8 to +7) and added only on cycles where `smp_en` is 1.
- R4: A dump pulse in `ST_INTEG` has three effects. On the next clock, `dump_sum` holds the epoch sum including that cycle's enabled sample. `dump_vld` is 1 for exactly that one clock. The running sum restarts from zero.
- R5: Between dumps, `dump_sum` and `dump_ovf` keep their last reported values.
- R6: An addition that would exceed +32767 or fall below -32768 clips to that limit, and integration continues from the clipped value. `dump_ovf` is reported with the dump as 1 if any addition in that epoch clipped, including the dump cycle's own sample. Otherwise it is 0.
- R7: The dump counter counts reported dumps from 0 to 19 and wraps. `bit_edge` is 1 together with `dump_vld` on the dump that takes the counter from 19 back to 0, and is 0 at all other times.
- R8: `resync_i` clears the dump counter to 0. A dump pulse on the same cycle is still reported, but it is not counted and it raises no `bit_edge`.
- R9: Dump pulses on consecutive cycles each report an epoch. The sum of a one-cycle epoch is that cycle's enabled sample alone.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| smp_en | input | 1 | Sample enable |
| smp_prod | input | 4 | Signed correlation product |
| dump_i | input | 1 | End-of-epoch pulse from the code generator |
| resync_i | input | 1 | Clears the dump counter |
| dump_sum | output | 16 | Signed sum of the last reported epoch |
| dump_vld | output | 1 | One-cycle strobe for a new `dump_sum` |
| dump_ovf | output | 1 | The last reported epoch clipped |
| bit_edge | output | 1 | Strobe on the dump that closes a 20-epoch group |

## Verification
The bench targets the epoch edges.
- The sample that arrives on the dump cycle must land in the finished sum and not in the next epoch. A design that got this wrong would show every sum shifted by one sample.
- The very first dump must report nothing. A design that got this wrong would emit a false strobe and a sum built from pre-alignment samples.
- Long runs of +7 and of -8 push the sum to both limits. Wrapping instead of clipping would flip the sign of the result. A flag that was not reset between epochs would stay set on the following clean epoch.
- Twenty-five short epochs and two resyncs, one mid-group and one on a dump cycle, test the bit strobe. A counter off by one, or one that counts the resync dump, would place the strobe on the wrong dump.

// File: rtl/ei_pkg.sv
package ei_pkg;

    typedef enum logic [0:0] {
        ST_WAIT  = 1'b0,
        ST_INTEG = 1'b1
    } ei_state_e;

endpackage

// File: rtl/ei_sat_add.sv
module ei_sat_add #(
    parameter int SUM_W  = 16,
    parameter int PROD_W = 4
) (
    input  logic signed [SUM_W-1:0]  acc_i,
    input  logic signed [PROD_W-1:0] add_i,
    output logic signed [SUM_W-1:0]  sum_o,
    output logic                     sat_o
);
    localparam int WIDE_W = SUM_W + 1;
    localparam logic signed [SUM_W-1:0] MAX_V = {1'b0, {(SUM_W-1){1'b1}}};
    localparam logic signed [SUM_W-1:0] MIN_V = {1'b1, {(SUM_W-1){1'b0}}};

    logic signed [WIDE_W-1:0] wide_acc;
    logic signed [WIDE_W-1:0] wide_add;
    logic signed [WIDE_W-1:0] wide_sum;

    always_comb begin
        wide_acc = WIDE_W'(acc_i);
        wide_add = WIDE_W'(add_i);
        wide_sum = wide_acc + wide_add;
        sat_o    = wide_sum[WIDE_W-1] != wide_sum[WIDE_W-2];
        if (sat_o) begin
            sum_o = wide_sum[WIDE_W-1] ? MIN_V : MAX_V;
        end else begin
            sum_o = wide_sum[SUM_W-1:0];
        end
    end

endmodule

// File: rtl/ei_dump_counter.sv
module ei_dump_counter #(
    parameter int EPOCHS = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic count_i,
    input  logic clear_i,
    output logic edge_o
);
    localparam int CNT_W = (EPOCHS > 1) ? $clog2(EPOCHS) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(EPOCHS - 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear_i) begin
            cnt_q <= '0;
        end else if (count_i) begin
            cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
        end
    end

    assign edge_o = count_i && !clear_i && (cnt_q == LAST);

    // R7: counter never leaves its 0..EPOCHS-1 range
    p_cnt_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);

    // R8: resync leaves the counter at zero
    p_resync_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> cnt_q == '0);

endmodule

// File: rtl/epoch_integrator.sv
module epoch_integrator #(
    parameter int SUM_W  = 16,
    parameter int PROD_W = 4,
    parameter int EPOCHS = 20
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     smp_en,
    input  logic signed [PROD_W-1:0] smp_prod,
    input  logic                     dump_i,
    input  logic                     resync_i,
    output logic signed [SUM_W-1:0]  dump_sum,
    output logic                     dump_vld,
    output logic                     dump_ovf,
    output logic                     bit_edge
);
    import ei_pkg::*;

    localparam logic signed [SUM_W-1:0] MAX_V = {1'b0, {(SUM_W-1){1'b1}}};
    localparam logic signed [SUM_W-1:0] MIN_V = {1'b1, {(SUM_W-1){1'b0}}};

    ei_state_e                state_q, state_d;
    logic signed [SUM_W-1:0]  acc_q;
    logic                     ovf_run_q;
    logic signed [PROD_W-1:0] add_val;
    logic signed [SUM_W-1:0]  sum_w;
    logic                     sat_w;
    logic                     edge_w;
    logic                     count_dump;

    assign add_val    = smp_en ? smp_prod : '0;
    assign count_dump = (state_q == ST_INTEG) && dump_i;

    ei_sat_add #(.SUM_W(SUM_W), .PROD_W(PROD_W)) u_add (
        .acc_i (acc_q),
        .add_i (add_val),
        .sum_o (sum_w),
        .sat_o (sat_w)
    );

    ei_dump_counter #(.EPOCHS(EPOCHS)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .count_i (count_dump),
        .clear_i (resync_i),
        .edge_o  (edge_w)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_WAIT:  if (dump_i) state_d = ST_INTEG;  // first epoch
            ST_INTEG: state_d = ST_INTEG;              // epoch dump stays
            default:  state_d = ST_WAIT;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_WAIT;
        end else begin
            state_q <= state_d;
        end
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q     <= '0;
            ovf_run_q <= 1'b0;
            dump_sum  <= '0;
            dump_vld  <= 1'b0;
            dump_ovf  <= 1'b0;
            bit_edge  <= 1'b0;
        end else begin
            dump_vld <= 1'b0;
            bit_edge <= 1'b0;
            unique case (state_q)
                ST_WAIT: begin
                    acc_q     <= '0;
                    ovf_run_q <= 1'b0;
                end
                ST_INTEG: begin
                    if (dump_i) begin
                        dump_sum  <= sum_w;
                        dump_ovf  <= ovf_run_q | sat_w;
                        dump_vld  <= 1'b1;
                        bit_edge  <= edge_w;
                        acc_q     <= '0;
                        ovf_run_q <= 1'b0;
                    end else begin
                        acc_q     <= sum_w;
                        ovf_run_q <= ovf_run_q | sat_w;
                    end
                end
                default: begin
                    acc_q     <= '0;
                    ovf_run_q <= 1'b0;
                end
            endcase
        end
    end

    // R2: nothing accumulates or reports before the first epoch edge
    p_wait_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_WAIT |-> acc_q == '0 && !dump_vld);

    // R4: a strobe only follows a dump seen while integrating
    p_vld_follows_dump_r4: assert property (@(posedge clk) disable iff (!rst_n)
        dump_vld |-> $past(dump_i) && $past(state_q == ST_INTEG));

    // R4: every dump restarts the running sum at zero
    p_acc_restart_r4: assert property (@(posedge clk) disable iff (!rst_n)
        dump_i |=> acc_q == '0);

    // R5: reported result is held between strobes
    p_hold_result_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !dump_vld |-> $stable(dump_sum) && $stable(dump_ovf));

    // R6: a fresh overflow leaves the sum pinned at a limit
    p_no_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf_run_q) |-> acc_q == MAX_V || acc_q == MIN_V);

    // R7: bit strobe only rides on a dump strobe
    p_edge_with_vld_r7: assert property (@(posedge clk) disable iff (!rst_n)
        bit_edge |-> dump_vld);

endmodule

// File: tb/test_epoch_integrator.sv
`timescale 1ns/1ps
module test_epoch_integrator;
    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic               rst_n;
    logic               smp_en;
    logic signed [3:0]  smp_prod;
    logic               dump_i;
    logic               resync_i;
    logic signed [15:0] dump_sum;
    logic               dump_vld;
    logic               dump_ovf;
    logic               bit_edge;

    epoch_integrator i_epoch_integrator (
        .clk(clk), .rst_n(rst_n), .smp_en(smp_en), .smp_prod(smp_prod),
        .dump_i(dump_i), .resync_i(resync_i), .dump_sum(dump_sum),
        .dump_vld(dump_vld), .dump_ovf(dump_ovf), .bit_edge(bit_edge)
    );

    int    n_cmp = 0;
    int    n_bad = 0;
    string req   = "R1";

    // behavioural reference
    bit m_run = 0;
    int m_acc = 0;
    bit m_ovf = 0;
    int m_cnt = 0;
    int e_sum = 0;
    bit e_vld = 0, e_ovf = 0, e_edge = 0;

    task automatic chk(string what, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic compare_all();
        chk("dump_sum", int'(dump_sum), e_sum);
        chk("dump_vld", int'(dump_vld), int'(e_vld));
        chk("dump_ovf", int'(dump_ovf), int'(e_ovf));
        chk("bit_edge", int'(bit_edge), int'(e_edge));
    endtask

    task automatic cycle(bit en, int p, bit dmp, bit rs);
        int s;
        bit o;
        @(negedge clk);
        compare_all();
        smp_en   = en;
        smp_prod = 4'(p);
        dump_i   = dmp;
        resync_i = rs;
        e_vld  = 0;
        e_edge = 0;
        if (!m_run) begin
            if (dmp) m_run = 1;
            if (rs) m_cnt = 0;
        end else begin
            s = m_acc + (en ? p : 0);
            o = 0;
            if (s > 32767) begin s = 32767; o = 1; end
            if (s < -32768) begin s = -32768; o = 1; end
            if (dmp) begin
                e_sum  = s;
                e_ovf  = m_ovf | o;
                e_vld  = 1;
                e_edge = (m_cnt == 19) && !rs;
                m_cnt  = rs ? 0 : ((m_cnt == 19) ? 0 : m_cnt + 1);
                m_acc  = 0;
                m_ovf  = 0;
            end else begin
                m_acc = s;
                m_ovf = m_ovf | o;
                if (rs) m_cnt = 0;
            end
        end
    endtask

    task automatic epoch(int len, int p, bit en_alt);
        for (int k = 0; k < len - 1; k++) cycle(en_alt ? k[0] : 1'b1, p + (k % 3), 0, 0);
        cycle(1, p, 1, 0);
    endtask

    initial begin
        rst_n = 0; smp_en = 0; smp_prod = 0; dump_i = 0; resync_i = 0;
        repeat (3) @(negedge clk);
        req = "R1";
        compare_all();                           // R1 reset values
        rst_n = 1;
        cycle(0, 0, 0, 0);

        req = "R2";                              // samples before first edge ignored
        for (int k = 0; k < 10; k++) cycle(1, 7, 0, 0);
        cycle(1, 5, 1, 0);                       // first dump: no report
        cycle(0, 0, 0, 0);

        req = "R3";                              // mixed patterns, enable gaps
        epoch(30, -3, 0);
        epoch(30, 2, 1);
        for (int k = 0; k < 12; k++) cycle(1'b0, 7, 0, 0);
        cycle(1, -8, 1, 0);

        req = "R4";                              // dump-cycle sample lands in the sum
        for (int k = 0; k < 5; k++) cycle(1, 1, 0, 0);
        cycle(1, -6, 1, 0);
        cycle(1, 4, 0, 0);
        cycle(0, 4, 1, 0);

        req = "R5";                              // hold between strobes
        for (int k = 0; k < 8; k++) cycle(1, 3, 0, 0);
        cycle(1, 3, 1, 0);

        req = "R9";                              // back-to-back dumps
        cycle(1, 7, 1, 0);
        cycle(1, -8, 1, 0);
        cycle(0, 5, 1, 0);
        cycle(0, 0, 0, 0);

        req = "R8";                              // realign counter, then group of 20
        cycle(0, 0, 0, 1);
        req = "R7";
        for (int e = 0; e < 25; e++) epoch(5, e % 8 - 4, 0);

        req = "R8";                              // resync mid-group and on a dump
        for (int e = 0; e < 7; e++) epoch(3, 1, 0);
        cycle(1, 2, 0, 1);
        for (int e = 0; e < 10; e++) epoch(3, 1, 0);
        cycle(1, 1, 1, 1);
        for (int e = 0; e < 21; e++) epoch(2, -2, 0);

        req = "R6";                              // clip at both limits
        for (int k = 0; k < 4700; k++) cycle(1, 7, 0, 0);
        cycle(1, -8, 0, 0);
        cycle(1, 0, 1, 0);
        for (int k = 0; k < 4100; k++) cycle(1, -8, 0, 0);
        cycle(1, 7, 1, 0);
        for (int k = 0; k < 4096; k++) cycle(1, -8, 0, 0);
        cycle(0, 0, 1, 0);                       // exactly -32768, no clip
        for (int k = 0; k < 4681; k++) cycle(1, 7, 0, 0);
        cycle(1, 0, 1, 0);                       // 32767 exactly, no clip
        epoch(10, 1, 0);                         // clean epoch after clipping
        cycle(0, 0, 0, 0);
        cycle(0, 0, 0, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule